// File: doc/BRIEF.md
# Negacyclic NTT Butterfly Engine

This block holds one polynomial of the ring Z_q[x]/(x^n+1) in local storage and computes its forward Number Theoretic Transform in place. The defaults are n = 16 and q = 7681. A host writes coefficients one per cycle through an index-addressed load port and pulses `start`. The block then runs log2(n) stages of Cooley-Tukey butterflies. Each butterfly has one modular multiply with Barrett reduction, followed by a modular add and a modular subtract. At the end, `done` pulses and the host reads the result through an index-addressed unload port.

The twiddle factors are powers of psi = 1366, a primitive 32nd root of unity mod 7681. They are computed at elaboration, and this is what makes the transform negacyclic rather than cyclic. Every stored value stays fully reduced below q.

The same load port has a pointwise mode. In that mode each written value multiplies the stored coefficient mod q. Two transformed polynomials can therefore be multiplied element by element, which gives the transform of their negacyclic product.

Top module: `ntt_engine`

## Requirements
- R1: While and after reset, every stored coefficient reads 0, `busy` is 0 and `done` is 0.
- R2: When `busy` is low and `ld_en` is high with `ld_mul` low, `ld_data` is written to coefficient `ld_idx`. `rd_data` always shows coefficient `rd_idx` combinationally.
- R3: When `busy` is low and `ld_en` and `ld_mul` are both high, coefficient `ld_idx` becomes (old value × `ld_data`) mod q.
- R4: After a transform, output position i holds the sum over j of a_j·psi^((2·br(i)+1)·j) mod q. Here a is the stored input in natural order, psi = 1366, and br(i) is the 4-bit reversal of i. The output is therefore in bit-reversed evaluation order.
- R5: A `start` accepted while idle raises `busy` for exactly log2(n)·n/2 = 32 cycles. `done` is high for exactly one cycle, the first cycle in which `busy` is low again.
- R6: `start` while `busy` is high is ignored: neither the result nor the 32-cycle run length changes.
- R7: Loads and pointwise writes while `busy` is high are ignored and do not alter the result.
- R8: Given inputs below q, every stored coefficient stays below q at all times.
- R9: A `start` in the same cycle as `done` is accepted. A new transform then runs on the previous result.
- R10: A load in the same idle cycle as an accepted `start` is applied before the first butterfly.
- R11: Transforming a and b, then multiplying them pointwise, yields the transform of the negacyclic product a·b mod (x^16+1, q).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load strobe (honoured only while idle) |
| ld_mul | input | 1 | 0: overwrite, 1: multiply into stored coefficient mod q |
| ld_idx | input | 4 | Coefficient index for load |
| ld_data | input | 13 | Load value, must be below q |
| start | input | 1 | Begin a transform (honoured only while idle) |
| busy | output | 1 | Transform in progress |
| done | output | 1 | One-cycle pulse when the last stage has written |
| rd_idx | input | 4 | Coefficient index for unload |
| rd_data | output | 13 | Coefficient at `rd_idx` |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a load and a `start` in one idle cycle. The bench drives both together and expects a transform of the polynomial that already contains the new value. The second pair is the `done` pulse and a new `start`. The bench raises `start` at the very edge where `done` is seen, then expects `busy` in the next cycle, another 32-cycle run, and the transform of the previous transform. The bench also drives `start`, plain loads and pointwise writes in the middle of a run, and judges them by an unchanged result and unchanged run length.

// File: rtl/ntt_engine.sv
`timescale 1ns/1ps
module ntt_engine #(
  parameter int N   = 16,
  parameter int Q   = 7681,
  parameter int W   = 13,
  parameter int PSI = 1366
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_en,
  input  logic                 ld_mul,
  input  logic [$clog2(N)-1:0] ld_idx,
  input  logic [W-1:0]         ld_data,
  input  logic                 start,
  output logic                 busy,
  output logic                 done,
  input  logic [$clog2(N)-1:0] rd_idx,
  output logic [W-1:0]         rd_data
);
  localparam int LOGN  = $clog2(N);
  localparam int HALF  = N / 2;
  localparam int STEPS = LOGN * HALF;
  localparam int BK    = 2 * W;
  localparam longint BM = (longint'(1) << BK) / Q;
  localparam int MW    = 3 * W + 1;
  localparam int CW    = $clog2(STEPS + 1);
  localparam logic [W-1:0]  QW    = W'(Q);
  localparam logic [W:0]    Q1    = (W+1)'(Q);
  localparam logic [W+1:0]  Q2    = (W+2)'(Q);
  localparam logic [CW-1:0] LASTC = CW'(STEPS - 1);

  function automatic int unsigned rev(input int unsigned v);
    int unsigned r;
    r = 0;
    for (int i = 0; i < LOGN; i++) r = (r << 1) | ((v >> i) & 1);
    return r;
  endfunction

  function automatic int unsigned pow_psi(input int unsigned e);
    longint unsigned acc;
    acc = 1;
    for (int i = 0; i < int'(e); i++) acc = (acc * longint'(PSI)) % longint'(Q);
    return int'(acc);
  endfunction

  logic [W-1:0] mem [N];
  logic [W-1:0] tw  [N];

  for (genvar k = 0; k < N; k++) begin : g_tw
    assign tw[k] = W'(pow_psi(rev(k)));
  end

  logic [LOGN-1:0] stg;
  logic [LOGN-2:0] bfi;
  logic [LOGN-1:0] len, grp, lo, hi, zi;

  assign len = LOGN'(HALF) >> stg;
  assign grp = LOGN'(bfi) >> (LOGN'(LOGN - 1) - stg);
  assign lo  = (grp << (LOGN'(LOGN) - stg)) | (LOGN'(bfi) & (len - 1'b1));
  assign hi  = lo | len;
  assign zi  = (LOGN'(1) << stg) | grp;

  logic [W-1:0]   ma, mb, prod_r;
  logic [2*W-1:0] prod;
  logic [MW-1:0]  qest;
  logic [W:0]     quo;
  logic [W+1:0]   r0, r1;

  assign ma     = busy ? tw[zi]  : ld_data;
  assign mb     = busy ? mem[hi] : mem[ld_idx];
  assign prod   = (2*W)'(ma) * (2*W)'(mb);
  assign qest   = MW'(prod) * MW'(BM);
  assign quo    = (W+1)'(qest >> BK);
  assign r0     = (W+2)'(prod - (2*W)'(quo) * (2*W)'(Q));
  assign r1     = (r0 >= Q2) ? r0 - Q2 : r0;
  assign prod_r = W'((r1 >= Q2) ? r1 - Q2 : r1);

  logic [W-1:0] a0, sum_r, dif_r;
  logic [W:0]   sum_w;

  assign a0      = mem[lo];
  assign sum_w   = {1'b0, a0} + {1'b0, prod_r};
  assign sum_r   = W'((sum_w >= Q1) ? sum_w - Q1 : sum_w);
  assign dif_r   = (a0 >= prod_r) ? a0 - prod_r : a0 - prod_r + QW;
  assign rd_data = mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) mem[k] <= '0;
      busy <= 1'b0;
      done <= 1'b0;
      stg  <= '0;
      bfi  <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        mem[lo] <= sum_r;
        mem[hi] <= dif_r;
        bfi     <= bfi + 1'b1;
        if (bfi == (LOGN-1)'(HALF - 1)) begin
          stg <= stg + 1'b1;
          if (stg == LOGN'(LOGN - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
            stg  <= '0;
          end
        end
      end else begin
        if (start) busy <= 1'b1;
        if (ld_en) mem[ld_idx] <= ld_mul ? prod_r : ld_data;
      end
    end
  end

  logic [CW-1:0] run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_cnt <= '0;
    else        run_cnt <= busy ? run_cnt + 1'b1 : '0;
  end

  assert_start_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && run_cnt == '0));
  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run_cnt != LASTC) |=> busy);
  assert_busy_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run_cnt == LASTC) |=> (!busy && done));
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> busy);

  for (genvar k = 0; k < N; k++) begin : g_chk
    assert_coeff_reduced_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem[k] < QW);
  end
endmodule

// File: tb/ntt_engine_bench.sv
`timescale 1ns/1ps
module ntt_engine_bench;
  localparam int N = 16, Q = 7681, PSI = 1366, STEPS = 32;
  typedef int poly_t [N];

  logic clk = 1'b0, rst_n = 1'b0, ld_en = 1'b0, ld_mul = 1'b0, start = 1'b0;
  logic [3:0]  ld_idx = '0, rd_idx = '0;
  logic [12:0] ld_data = '0;
  logic        busy, done;
  logic [12:0] rd_data;

  ntt_engine u_ntt_engine (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_mul(ld_mul), .ld_idx(ld_idx),
    .ld_data(ld_data), .start(start), .busy(busy), .done(done),
    .rd_idx(rd_idx), .rd_data(rd_data));

  always #10 clk = ~clk;

  int passed = 0, total = 0;
  int pw [2*N];

  localparam int VEC [8][3] = '{
    '{2, 3, 6}, '{0, 5, 0}, '{100, 100, 2319}, '{7680, 7680, 1},
    '{7680, 2, 7679}, '{4000, 4000, 477}, '{1366, 1366, 7154}, '{1, 7680, 7680}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s: actual %0d expected %0d", req, act, exp);
  endtask

  function automatic int br4(input int v);
    return ((v & 1) << 3) | ((v & 2) << 1) | ((v & 4) >> 1) | ((v & 8) >> 3);
  endfunction

  function automatic int pat(input int kind, input int j);
    case (kind)
      0: return (j == 0) ? 1 : 0;
      1: return (j == 1) ? 1 : 0;
      2: return (j == 15) ? 1 : 0;
      3: return Q - 1;
      4: return (j * 481) % Q;
      default: return (j * j * 1237 + 55 * j + 9) % Q;
    endcase
  endfunction

  task automatic ref_ntt(input poly_t a, output poly_t r);
    for (int i = 0; i < N; i++) begin
      longint s = 0;
      for (int j = 0; j < N; j++)
        s += longint'(a[j]) * pw[((2 * br4(i) + 1) * j) % (2 * N)];
      r[i] = int'(s % Q);
    end
  endtask

  task automatic negconv(input poly_t a, input poly_t b, output poly_t c);
    longint acc [N];
    for (int k = 0; k < N; k++) acc[k] = 0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        longint p = (longint'(a[i]) * b[j]) % Q;
        if (i + j < N) acc[i + j] += p;
        else acc[i + j - N] += Q - p;
      end
    for (int k = 0; k < N; k++) c[k] = int'(acc[k] % Q);
  endtask

  task automatic put(input int idx, input int val, input bit mul);
    ld_en = 1'b1; ld_mul = mul; ld_idx = idx[3:0]; ld_data = val[12:0];
    @(negedge clk);
    ld_en = 1'b0; ld_mul = 1'b0;
  endtask

  task automatic load_poly(input poly_t a);
    for (int i = 0; i < N; i++) put(i, a[i], 1'b0);
  endtask

  task automatic read_poly(output poly_t r);
    for (int i = 0; i < N; i++) begin
      rd_idx = i[3:0];
      #1;
      r[i] = int'(rd_data);
    end
    @(negedge clk);
  endtask

  task automatic wait_done(inout int cyc);
    while (!done) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run(output int cyc);
    cyc = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc);
  endtask

  task automatic check_poly(input poly_t got, input poly_t exp, input string req);
    for (int i = 0; i < N; i++) begin
      chk(got[i] == exp[i], req, got[i], exp[i]);
      chk(got[i] < Q, "R8", got[i], Q - 1);
    end
  endtask

  task automatic check_run(input int cyc, input string req);
    chk(cyc == STEPS, req, cyc, STEPS);
    chk(busy == 1'b0, "R5", int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    $display("FAIL R5: watchdog expired, actual timeout expected done");
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    poly_t a, b, got, exp, t1, ah;
    int cyc;
    int v;
    pw[0] = 1;
    for (int e = 1; e < 2 * N; e++) pw[e] = int'((longint'(pw[e-1]) * PSI) % Q);

    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1", int'({busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    read_poly(got);
    for (int i = 0; i < N; i++) chk(got[i] == 0, "R1", got[i], 0);
    chk(busy == 1'b0 && done == 1'b0, "R1", int'({busy, done}), 0);

    // Table of pointwise vectors (R2 overwrite, then R3 multiply)
    for (int i = 0; i < 8; i++) begin
      put(i, VEC[i][0], 1'b0);
      rd_idx = i[3:0]; #1; v = int'(rd_data);
      chk(v == VEC[i][0], "R2", v, VEC[i][0]);
      put(i, VEC[i][1], 1'b1);
      rd_idx = i[3:0]; #1; v = int'(rd_data);
      chk(v == VEC[i][2], "R3", v, VEC[i][2]);
    end
    @(negedge clk);

    // Transform of several patterns (R4, R5)
    for (int k = 0; k < 6; k++) begin
      for (int j = 0; j < N; j++) a[j] = pat(k, j);
      load_poly(a);
      run(cyc);
      check_run(cyc, "R5");
      @(negedge clk);
      chk(done == 1'b0, "R5", int'(done), 0);
      read_poly(got);
      ref_ntt(a, exp);
      check_poly(got, exp, "R4");
    end

    // start, load and pointwise during a run (R6, R7)
    for (int j = 0; j < N; j++) a[j] = pat(5, j);
    load_poly(a);
    cyc = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    cyc = 4;
    start = 1'b1; ld_en = 1'b1; ld_mul = 1'b0; ld_idx = 4'd0; ld_data = 13'd1234;
    @(negedge clk);
    ld_mul = 1'b1; ld_idx = 4'd9;
    @(negedge clk);
    start = 1'b0; ld_en = 1'b0; ld_mul = 1'b0;
    cyc = 6;
    wait_done(cyc);
    check_run(cyc, "R6");
    read_poly(got);
    ref_ntt(a, exp);
    check_poly(got, exp, "R7");

    // start in the done cycle (R9)
    for (int j = 0; j < N; j++) a[j] = pat(4, j);
    load_poly(a);
    run(cyc);
    check_run(cyc, "R5");
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9", int'(busy), 1);
    cyc = 0;
    wait_done(cyc);
    check_run(cyc, "R9");
    read_poly(got);
    ref_ntt(a, t1);
    ref_ntt(t1, exp);
    check_poly(got, exp, "R9");

    // load together with start (R10)
    for (int j = 0; j < N; j++) a[j] = pat(3, j);
    load_poly(a);
    a[5] = 77;
    start = 1'b1; ld_en = 1'b1; ld_idx = 4'd5; ld_data = 13'd77;
    @(negedge clk);
    start = 1'b0; ld_en = 1'b0;
    cyc = 0;
    wait_done(cyc);
    check_run(cyc, "R10");
    read_poly(got);
    ref_ntt(a, exp);
    check_poly(got, exp, "R10");

    // negacyclic product through pointwise mode (R11)
    for (int j = 0; j < N; j++) begin
      a[j] = pat(5, j);
      b[j] = pat(4, j);
    end
    load_poly(a);
    run(cyc);
    read_poly(ah);
    load_poly(b);
    run(cyc);
    @(negedge clk);
    for (int i = 0; i < N; i++) put(i, ah[i], 1'b1);
    read_poly(got);
    negconv(a, b, t1);
    ref_ntt(t1, exp);
    check_poly(got, exp, "R11");

    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule